// File: doc/BRIEF.md
# Write-Latched Paged ROM Window Controller

This block sits between a 16-bit CPU bus and two synchronous ROM arrays. The top 16 KiB of the address space, 0xC000 to 0xFFFF, is a window onto one of eight 16 KiB pages of a 128 KiB paged array. The page shown is held in a 3-bit page register. A write cycle to any address inside the window loads that register from the low data bits. The ROM contents never change, and the write returns no read data. Just below the window, 0xA000 to 0xBFFF maps to a separate 8 KiB unbanked array. That region holds the page-switching routines, so it stays visible whatever page is latched. Everything below 0xA000, including the 8 KiB RAM at the bottom of the map, is never claimed by either array.

On a read cycle the controller drives the address and enable of the selected array in the same cycle. Both arrays register their output. One cycle later the controller returns the data with `rd_valid`. A small state machine remembers which array was read. It has three states: `ST_IDLE` (no read data due), `ST_WIN_RD` (paged array data due) and `ST_FIX_RD` (unbanked array data due). On every clock it moves to `ST_WIN_RD` after a window read, to `ST_FIX_RD` after a read of the unbanked region, and to `ST_IDLE` after anything else: a write, no request, or an address below 0xA000.

Top module: `paged_rom_ctrl`

## Requirements
- R1: After reset the page register is 0, the state is ST_IDLE and `rd_valid` is 0.
- R2: A read with address in 0xC000-0xFFFF asserts `page_rom_en` in the same cycle with `page_rom_addr` = {page[2:0], addr[13:0]}.
- R3: A write with address in 0xC000-0xFFFF loads the page register from wdata[2:0] and ignores wdata[7:3]. The new page is used by the next read.
- R4: A write cycle never asserts `page_rom_en` or `fix_rom_en`, and it produces no `rd_valid`.
- R5: A read with address in 0xA000-0xBFFF asserts `fix_rom_en` with `fix_rom_addr` = addr[12:0]. The result does not depend on the page register.
- R6: Accesses below 0xA000, including the RAM at 0x0000-0x1FFF, assert neither ROM enable and produce no `rd_valid`.
- R7: Exactly one cycle after a ROM read, `rd_valid` is 1 and `rd_data` carries the registered output of the array that was read.
- R8: Writes outside 0xC000-0xFFFF leave the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus cycle valid this clock |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| page_rom_en | output | 1 | Read enable of the paged array |
| page_rom_addr | output | 17 | Paged array index {page, offset} |
| page_rom_data | input | 8 | Registered output of the paged array |
| fix_rom_en | output | 1 | Read enable of the unbanked array |
| fix_rom_addr | output | 13 | Unbanked array index |
| fix_rom_data | input | 8 | Registered output of the unbanked array |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data returned to the CPU |

## Verification
The hardest case to reach is a back-to-back sequence: a window write followed at once by a window read. It must show that the page register takes effect on the very next cycle and that the write left no stray response. The bench issues page-change writes between consecutive reads to the same window offset, so a wrong page shows up as a data mismatch. Some of these writes set bit patterns in wdata[7:3], and some land in the unbanked region or in RAM. Unbanked reads are repeated under different latched pages to show that page changes do not affect them.

// File: rtl/paged_rom_pkg.sv
package paged_rom_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 3;
    localparam int WIN_W  = 14;
    localparam int FIX_W  = 13;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WIN_RD = 2'd1,
        ST_FIX_RD = 2'd2
    } rsp_state_t;
endpackage

// File: rtl/paged_rom_decode.sv
module paged_rom_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_W    = 14,
    parameter int FIX_W    = 13,
    parameter logic [15:0] WIN_BASE = 16'hC000,
    parameter logic [15:0] FIX_BASE = 16'hA000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              win_hit,
    output logic              fix_hit
);
    localparam int WIN_TAG_W = ADDR_W - WIN_W;
    localparam int FIX_TAG_W = ADDR_W - FIX_W;
    localparam logic [WIN_TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_W];
    localparam logic [FIX_TAG_W-1:0] FIX_TAG = FIX_BASE[ADDR_W-1:FIX_W];

    always_comb begin
        win_hit = (addr[ADDR_W-1:WIN_W] == WIN_TAG);
        fix_hit = (addr[ADDR_W-1:FIX_W] == FIX_TAG);
    end
endmodule

// File: rtl/paged_rom_page_reg.sv
module paged_rom_page_reg #(
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (load)
            page <= wdata[PAGE_W-1:0];
    end

    // R8: page only moves on a window write
    a_r8_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page));
    // R3: a window write takes the low data bits
    a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> page == $past(wdata[PAGE_W-1:0]));
endmodule

// File: rtl/paged_rom_rsp_fsm.sv
module paged_rom_rsp_fsm
    import paged_rom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_rd,
    input  logic              fix_rd,
    input  logic [DATA_W-1:0] page_rom_data,
    input  logic [DATA_W-1:0] fix_rom_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    rsp_state_t state, state_nx;

    always_comb begin
        if (win_rd)
            state_nx = ST_WIN_RD;
        else if (fix_rd)
            state_nx = ST_FIX_RD;
        else
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state)
            ST_IDLE: begin
                rd_valid = 1'b0;
            end
            ST_WIN_RD: begin
                rd_valid = 1'b1;
                rd_data  = page_rom_data;
            end
            ST_FIX_RD: begin
                rd_valid = 1'b1;
                rd_data  = fix_rom_data;
            end
            default: begin
                rd_valid = 1'b0;
            end
        endcase
    end

    // R7: every ROM read gets a response on the next cycle
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd || fix_rd) |=> rd_valid);
    // R4: no response without a preceding ROM read
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_rd || fix_rd) |=> !rd_valid);
endmodule

// File: rtl/paged_rom_ctrl.sv
module paged_rom_ctrl
    import paged_rom_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    page_rom_en,
    output logic [PAGE_W+WIN_W-1:0] page_rom_addr,
    input  logic [DATA_W-1:0]       page_rom_data,
    output logic                    fix_rom_en,
    output logic [FIX_W-1:0]        fix_rom_addr,
    input  logic [DATA_W-1:0]       fix_rom_data,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data
);
    logic              win_hit, fix_hit;
    logic              win_rd, fix_rd, win_wr;
    logic [PAGE_W-1:0] page;

    paged_rom_decode #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .FIX_W(FIX_W)
    ) u_decode (
        .addr   (bus_addr),
        .win_hit(win_hit),
        .fix_hit(fix_hit)
    );

    always_comb begin
        win_rd = bus_req && !bus_we && win_hit;
        fix_rd = bus_req && !bus_we && fix_hit;
        win_wr = bus_req &&  bus_we && win_hit;
    end

    paged_rom_page_reg #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
        .clk  (clk),
        .rst_n(rst_n),
        .load (win_wr),
        .wdata(bus_wdata),
        .page (page)
    );

    always_comb begin
        page_rom_en   = win_rd;
        page_rom_addr = {page, bus_addr[WIN_W-1:0]};
        fix_rom_en    = fix_rd;
        fix_rom_addr  = bus_addr[FIX_W-1:0];
    end

    paged_rom_rsp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_rd       (win_rd),
        .fix_rd       (fix_rd),
        .page_rom_data(page_rom_data),
        .fix_rom_data (fix_rom_data),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

    // R4: write cycles never enable an array
    a_r4_write_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> !(page_rom_en || fix_rom_en));
    // R6: low addresses (RAM and below the unbanked region) are never claimed
    a_r6_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr < 16'hA000) |-> !(page_rom_en || fix_rom_en));
    // R2/R5: at most one array enabled at a time
    a_r5_one_array: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_rom_en && fix_rom_en));
endmodule

// File: tb/test_paged_rom_ctrl.sv
module test_paged_rom_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        page_rom_en, fix_rom_en, rd_valid;
    logic [16:0] page_rom_addr;
    logic [12:0] fix_rom_addr;
    logic [7:0]  page_rom_data = '0, fix_rom_data = '0, rd_data;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [2:0] exp_page = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    paged_rom_ctrl i_paged_rom_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .page_rom_en(page_rom_en), .page_rom_addr(page_rom_addr),
        .page_rom_data(page_rom_data), .fix_rom_en(fix_rom_en),
        .fix_rom_addr(fix_rom_addr), .fix_rom_data(fix_rom_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [7:0] p_fn(logic [16:0] i);
        return 8'(i[7:0] + 8'(i[16:14]) * 8'd37 + 8'(i[13:8]));
    endfunction
    function automatic logic [7:0] f_fn(logic [12:0] i);
        return 8'(~i[7:0] ^ (8'(i[12:8]) * 8'd3));
    endfunction

    // synchronous ROM models
    always @(posedge clk) begin
        if (page_rom_en) page_rom_data <= p_fn(page_rom_addr);
        if (fix_rom_en)  fix_rom_data  <= f_fn(fix_rom_addr);
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: one bus cycle, checks enables, pushes expected read data
    task automatic access(bit we, logic [15:0] a, logic [7:0] d);
        bit win, fix;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        win = (a[15:14] == 2'b11);
        fix = (a[15:13] == 3'b101);
        #1;
        if (we) begin
            check(!page_rom_en && !fix_rom_en, "R4 write enables",
                  {page_rom_en, fix_rom_en}, 0);
        end else if (win) begin
            check(page_rom_en && !fix_rom_en, "R2 window enable",
                  {page_rom_en, fix_rom_en}, 2);
            check(page_rom_addr == {exp_page, a[13:0]}, "R2 window index",
                  page_rom_addr, {exp_page, a[13:0]});
            exp_q.push_back(p_fn({exp_page, a[13:0]}));
            tag_q.push_back("R7 window data (R3 page)");
        end else if (fix) begin
            check(fix_rom_en && !page_rom_en, "R5 fixed enable",
                  {page_rom_en, fix_rom_en}, 1);
            check(fix_rom_addr == a[12:0], "R5 fixed index", fix_rom_addr, a[12:0]);
            exp_q.push_back(f_fn(a[12:0]));
            tag_q.push_back("R5 fixed data");
        end else begin
            check(!page_rom_en && !fix_rom_en, "R6 low address enables",
                  {page_rom_en, fix_rom_en}, 0);
        end
        if (we && win) exp_page = d[2:0];
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // monitor: compares each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4/R6 unexpected rd_valid", 1, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        #1;
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        // R1: page 0 after reset, seen through a window read
        access(0, 16'hC123, 8'h00);
        access(0, 16'hFFFF, 8'h00);
        // R3: back-to-back write then read, same offset
        for (int p = 1; p < 8; p++) begin
            access(1, 16'hD000 + 16'(p), 8'(p));
            access(0, 16'hC123, 8'h00);
        end
        // R3: upper data bits ignored
        access(1, 16'hE555, 8'hFD);
        access(0, 16'hC123, 8'h00);
        access(1, 16'hFFFF, 8'hA2);
        access(0, 16'hC000, 8'h00);
        // R8: writes to unbanked region and RAM leave page alone
        access(1, 16'hA010, 8'h07);
        access(1, 16'h0100, 8'h05);
        access(1, 16'h8000, 8'h01);
        access(0, 16'hC123, 8'h00);
        // R5: unbanked reads under different pages
        access(0, 16'hA000, 8'h00);
        access(0, 16'hBFFF, 8'h00);
        access(1, 16'hC000, 8'h06);
        access(0, 16'hA000, 8'h00);
        access(0, 16'hB3C4, 8'h00);
        // R6: RAM and other low addresses unclaimed
        access(0, 16'h0000, 8'h00);
        access(0, 16'h1FFF, 8'h00);
        access(0, 16'h9FFF, 8'h00);
        // R7: mixed back-to-back reads
        access(0, 16'hF0F0, 8'h00);
        access(0, 16'hA5A5, 8'h00);
        access(0, 16'hC001, 8'h00);
        idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 outstanding responses", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule